// File: doc/BRIEF.md
# Selectable Dot Clock Divider

This block paces a video serializer from one oscillator. It turns a fast system clock into a one-cycle dot strobe. Six fixed division ratios are available, so one crystal can serve several print resolutions: for example, 300 dpi, 600 dpi and 1200 dpi scan rates in one or both directions. Each resolution uses its own ratio.

Every ratio is made from two parts: a prescale count and an edge mode.
- In rising-edge-only mode, the prescaler advances once per oscillator period.
- In both-edge mode, it advances twice per oscillator period.

Counting on both edges is modelled synthesizably. The block runs from `clk2x`, a clock at twice the oscillator rate. In rising-edge-only mode the prescaler advances on every other `clk2x` cycle. In both-edge mode it advances on every `clk2x` cycle. The output is a clock enable, not a derived clock, so the serializer stays in the `clk2x` domain.

A new ratio selection is taken into the active setting only at a terminal count, or at any time while the divider is disabled. No dot period is ever cut short or stretched. Disabling the divider clears the prescaler and the strobe. Enabling it again starts a fresh period from zero.

Top module: `dot_clock_divider`

## Requirements
- R1: After reset, `dot_strobe` is low, and it stays low for as long as `enable` is low.
- R2: The code on `ratio_sel` sets the division ratio, in oscillator periods, as follows:
  - code 0 gives 32 and code 1 gives 24, both in rising-edge-only mode.
  - code 2 gives 16, code 3 gives 12, code 4 gives 8 and code 5 gives 4, all in both-edge mode.
  - The strobe therefore repeats every 2×ratio cycles of `clk2x`.
- R3: Codes 6 and 7 select ratio 32, which is a strobe every 64 `clk2x` cycles.
- R4: `dot_strobe` is high for exactly one `clk2x` cycle per dot period.
- R5: Let N be 2×ratio. When `enable` is first sampled high at rising edge k of `clk2x`, the first strobe is high in the cycle after edge k+N-1. That is N edges, counted from the enabling edge itself.
- R6: When `enable` is sampled low, the prescaler is cleared and the strobe goes low at the same edge. Re-enabling the divider restarts timing from zero, as in R5.
- R7: While the divider is enabled, a change on `ratio_sel` does not alter the period in progress. The value present at the edge of the terminal count sets the length of the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the oscillator rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the divider while high; clears it while low |
| ratio_sel | input | 3 | Division ratio code (see R2, R3) |
| dot_strobe | output | 1 | One-cycle dot enable for the serializer |

## Verification
The bound checker watches four properties on every cycle:
- the strobe stays one cycle wide;
- the strobe stays quiet after a disable;
- the prescaler never reaches or passes its active prescale value;
- the active setting changes only at a terminal count or while disabled.

It also checks that each strobe-to-strobe gap matches the period of the setting that was loaded at the previous terminal count. Other behaviours only the directed scenarios can show:
- the mapping from each code to its absolute ratio, including the fallback codes;
- the exact delay from enable to the first strobe;
- that a mid-period ratio change is deferred, while a change at the terminal edge is taken at once;
- the restart after a disable.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

  localparam int SEL_W = 3;
  localparam int CNT_W = 6;
  localparam int PER_W = CNT_W + 1;

  typedef struct packed {
    logic             both_edge;
    logic [CNT_W-1:0] prescale;
  } ratio_cfg_t;

  // Code to (edge mode, prescale). Rising-only: one tick per two clk2x cycles.
  function automatic ratio_cfg_t decode_ratio(input logic [SEL_W-1:0] code);
    ratio_cfg_t c;
    case (code)
      3'd1:    c = '{both_edge: 1'b0, prescale: CNT_W'(24)};
      3'd2:    c = '{both_edge: 1'b1, prescale: CNT_W'(32)};
      3'd3:    c = '{both_edge: 1'b1, prescale: CNT_W'(24)};
      3'd4:    c = '{both_edge: 1'b1, prescale: CNT_W'(16)};
      3'd5:    c = '{both_edge: 1'b1, prescale: CNT_W'(8)};
      default: c = '{both_edge: 1'b0, prescale: CNT_W'(32)};
    endcase
    return c;
  endfunction

  // Dot period measured in clk2x cycles.
  function automatic logic [PER_W-1:0] period_of(input ratio_cfg_t c);
    return c.both_edge ? {1'b0, c.prescale} : {c.prescale, 1'b0};
  endfunction

endpackage

// File: rtl/dclk_ratio_reg.sv
module dclk_ratio_reg
  import dclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             term_count,
  input  logic [SEL_W-1:0] ratio_sel,
  output ratio_cfg_t       cfg_q
);

  // Follows the select while idle; otherwise reloads only at a period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cfg_q <= decode_ratio('0);
    else if (!enable || term_count) cfg_q <= decode_ratio(ratio_sel);
  end

endmodule

// File: rtl/dclk_edge_gate.sv
module dclk_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic both_edge,
  input  logic term_count,
  output logic tick
);

  logic phase_q;

  // phase_q marks the second half of an oscillator period in rising-only mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    phase_q <= 1'b0;
    else if (!enable || term_count) phase_q <= 1'b0;
    else                           phase_q <= ~phase_q;
  end

  assign tick = both_edge | phase_q;

endmodule

// File: rtl/dclk_prescaler.sv
module dclk_prescaler #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] prescale,
  output logic [CNT_W-1:0] cnt_q,
  output logic             term_count
);

  logic at_last;

  assign at_last    = (cnt_q == prescale - CNT_W'(1));
  assign term_count = enable & tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!enable)    cnt_q <= '0;
    else if (term_count) cnt_q <= '0;
    else if (tick)       cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/dot_clock_divider.sv
module dot_clock_divider
  import dclk_pkg::*;
(
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             dot_strobe
);

  ratio_cfg_t       cfg;
  logic             tick;
  logic             term_count;
  logic [CNT_W-1:0] cnt;

  dclk_ratio_reg u_ratio (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .enable    (enable),
    .term_count(term_count),
    .ratio_sel (ratio_sel),
    .cfg_q     (cfg)
  );

  dclk_edge_gate u_edge (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .enable    (enable),
    .both_edge (cfg.both_edge),
    .term_count(term_count),
    .tick      (tick)
  );

  dclk_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .prescale  (cfg.prescale),
    .cnt_q     (cnt),
    .term_count(term_count)
  );

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) dot_strobe <= 1'b0;
    else        dot_strobe <= term_count;
  end

endmodule

// File: rtl/dclk_checker.sv
module dclk_checker
  import dclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             dot_strobe,
  input logic             term_count,
  input logic [CNT_W-1:0] cnt,
  input ratio_cfg_t       cfg
);

  localparam int GAP_W = PER_W + 1;

  logic [GAP_W-1:0] gap_q;
  logic [PER_W-1:0] exp_q;
  logic             have_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= '0;
      exp_q       <= '0;
      have_prev_q <= 1'b0;
    end else if (!enable) begin
      gap_q       <= '0;
      have_prev_q <= 1'b0;
    end else if (dot_strobe) begin
      gap_q       <= GAP_W'(1);
      exp_q       <= period_of(cfg);
      have_prev_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dot_strobe |=> !dot_strobe); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dot_strobe); // R6

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cfg.prescale); // R2

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_strobe && have_prev_q) |-> (gap_q == {1'b0, exp_q})); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !term_count) |=> $stable(cfg)); // R7

endmodule

bind dot_clock_divider dclk_checker u_chk (
  .clk       (clk2x),
  .rst_n     (rst_n),
  .enable    (enable),
  .dot_strobe(dot_strobe),
  .term_count(term_count),
  .cnt       (cnt),
  .cfg       (cfg)
);

// File: tb/dot_clock_divider_tb.sv
module dot_clock_divider_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk2x = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic       dot_strobe;

  int checks = 0;
  int fails  = 0;

  dot_clock_divider u_dut (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .enable    (enable),
    .ratio_sel (ratio_sel),
    .dot_strobe(dot_strobe)
  );

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  // Ratio in oscillator periods per requirement table; strobe period is twice that.
  function automatic int cycles_for(input int code);
    int ratio;
    case (code)
      0: ratio = 32; 1: ratio = 24; 2: ratio = 16;
      3: ratio = 12; 4: ratio = 8;  5: ratio = 4;
      default: ratio = 32;
    endcase
    return 2 * ratio;
  endfunction

  task automatic report(input bit ok, input string req, input string what,
                        input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Each period: strobe low for n-1 samples, high on sample n-1.
  task automatic check_periods(input int n, input int periods, input string req);
    for (int p = 0; p < periods; p++) begin
      int bad_j = -1;
      int bad_v = 0;
      for (int j = 0; j < n; j++) begin
        @(negedge clk2x);
        if (dot_strobe !== (j == n - 1) && bad_j < 0) begin
          bad_j = j; bad_v = dot_strobe;
        end
      end
      report(bad_j < 0, req, $sformatf("period len %0d strobe at sample %0d", n, bad_j),
             bad_v, (bad_j == n - 1) ? 1 : 0);
    end
  endtask

  task automatic go_idle();
    @(negedge clk2x);
    enable = 1'b0;
    repeat (3) @(negedge clk2x);
  endtask

  task automatic t_reset();
    bit ok = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk2x);
    report(dot_strobe === 1'b0, "R1", "strobe in reset", dot_strobe, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk2x);
      if (dot_strobe !== 1'b0) ok = 1'b0;
    end
    report(ok, "R1", "strobe while never enabled", ok ? 0 : 1, 0);
  endtask

  // R2/R3/R5: ratio per code, first strobe timing and steady repetition.
  task automatic t_code(input int code, input string req);
    ratio_sel = 3'(code);
    repeat (2) @(negedge clk2x);
    enable = 1'b1;
    check_periods(cycles_for(code), 3, req);
    go_idle();
  endtask

  // R6: disable mid-period, stays quiet, restarts from zero.
  task automatic t_disable_restart();
    bit ok = 1'b1;
    ratio_sel = 3'd5;
    repeat (2) @(negedge clk2x);
    enable = 1'b1;
    repeat (3) @(negedge clk2x);
    enable = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk2x);
      if (dot_strobe !== 1'b0) ok = 1'b0;
    end
    report(ok, "R6", "strobe while disabled", ok ? 0 : 1, 0);
    enable = 1'b1;
    check_periods(cycles_for(5), 2, "R6");
    go_idle();
  endtask

  // R7: change mid-period is deferred to the next period.
  task automatic t_change_mid();
    int bad = -1;
    ratio_sel = 3'd4;
    repeat (2) @(negedge clk2x);
    enable = 1'b1;
    for (int j = 0; j < 16; j++) begin
      @(negedge clk2x);
      if (dot_strobe !== (j == 15) && bad < 0) bad = j;
      if (j == 5) ratio_sel = 3'd5;
    end
    report(bad < 0, "R7", "old period kept after change (bad sample)", bad, -1);
    check_periods(8, 2, "R7");
    go_idle();
  endtask

  // R7: change present at the terminal-count edge is taken immediately.
  task automatic t_change_at_term();
    int bad = -1;
    ratio_sel = 3'd0;
    repeat (2) @(negedge clk2x);
    enable = 1'b1;
    for (int j = 0; j < 64; j++) begin
      @(negedge clk2x);
      if (dot_strobe !== (j == 63) && bad < 0) bad = j;
      if (j == 62) ratio_sel = 3'd3;
    end
    report(bad < 0, "R7", "period before terminal change (bad sample)", bad, -1);
    check_periods(24, 2, "R7");
    go_idle();
  endtask

  initial begin
    t_reset();
    for (int c = 0; c < 6; c++) t_code(c, "R2");
    t_code(6, "R3");
    t_code(7, "R3");
    t_code(3, "R5");
    t_disable_restart();
    t_change_mid();
    t_change_at_term();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk2x);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule